// File: doc/BRIEF.md
# Software Interrupt Masking Unit

This block keeps a 17-bit software interrupt word and a 4-bit processor interrupt level (PIL). From these two values it drives one pending-request line for each interrupt level to the CPU core. Software reaches the word through a small register bus. The bus offers four write addresses: one replaces the whole word, one ORs data into it, one clears the bits written as 1, and one loads the PIL.

A timer-match input sets the system-timer bit through the same merge path that a software set uses. Two special bits, the tick match (bit 0) and the system-timer match (bit 16), share request level 14. They are gated as a pair against the PIL. Each ordinary bit from 1 to 15 requests its own level, but only when that level is strictly above the PIL.

Register and PIL writes take effect on the clock edge. The request lines are registered from the stored state, so they follow one cycle after the state changes. Reads are combinational from the stored state.

Top module: `softint_mask_unit`

## Requirements
- R1: While PIL is below 14, a set bit 16 (system-timer match) raises request level 14. At PIL 14 or 15, bit 16 contributes no request.
- R2: While PIL is below 14, a set bit 0 (tick match) raises request level 14. At PIL 14 or 15, bit 0 contributes no request.
- R3: For each bit n from 1 to 15, request level n is raised when bit n is set and n is strictly greater than PIL. At n equal to PIL, the bit is masked. Request line 0 is always low.
- R4: A write to address 1 ORs the 17 written bits into the word.
- R5: A write to address 2 clears every word bit whose written bit is 1 and leaves all other bits unchanged.
- R6: A write to address 0 replaces the word. A write to address 3 loads PIL from the low 4 data bits. Either write re-evaluates every request line, with no other write needed.
- R7: A timer-match pulse sets bit 16. When it coincides with a software write, it is applied after that write, so bit 16 ends set even under a clear of bit 16.
- R8: A write changes the stored state on the clock edge that samples it. The request lines change on the following edge and hold their old value until then.
- R9: After reset the word is 0, PIL is 0 and every request line is low.
- R10: A read at address 3 returns PIL zero-extended to 64 bits. A read at any other address returns the word zero-extended to 64 bits. The read reflects the state stored at the last edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 replace, 1 set, 2 clear, 3 PIL |
| wrData | input | 17 | Write data |
| timerHit | input | 1 | Timer-match pulse that sets bit 16 |
| rdAddr | input | 2 | Read address |
| rdData | output | 64 | Read data, zero-extended |
| levelReq | output | 16 | Pending request per level; index is the level |

## Verification
The merge assertions assume that every write and timer pulse lasts one clock and that inputs are stable around the sampling edge. The clear and replace checks also assume that no timer pulse arrives in the same cycle, and they exclude that case explicitly. The stimulus drives every input on the falling edge and holds each write for exactly one cycle. Timer pulses that overlap writes are confined to the dedicated concurrency cases. The sweep covers every PIL value against every single-bit word and then against a stream of pseudo-random words, so the threshold boundary, where the level equals PIL, is hit for every level.

// File: rtl/softint_pkg.sv
package softint_pkg;

  // Register-bus address codes (bus-visible encoding)
  localparam logic [1:0] ADDR_DIRECT = 2'd0;
  localparam logic [1:0] ADDR_SET    = 2'd1;
  localparam logic [1:0] ADDR_CLR    = 2'd2;
  localparam logic [1:0] ADDR_PIL    = 2'd3;

  // Control-to-datapath strobes
  typedef struct packed {
    logic wrDirect;
    logic wrSet;
    logic wrClr;
    logic wrPil;
    logic timerSet;
  } softStrobe_t;

endpackage

// File: rtl/softint_ctrl.sv
module softint_ctrl
  import softint_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic        timerHit,
  output softStrobe_t strb
);

  always_comb begin
    strb          = '0;
    strb.timerSet = timerHit;
    if (wrEn) begin
      unique case (wrAddr)
        ADDR_DIRECT: strb.wrDirect = 1'b1;
        ADDR_SET:    strb.wrSet    = 1'b1;
        ADDR_CLR:    strb.wrClr    = 1'b1;
        ADDR_PIL:    strb.wrPil    = 1'b1;
        default:     strb          = strb;
      endcase
    end
  end

  AST_ONE_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrDirect, strb.wrSet, strb.wrClr, strb.wrPil})); // R6

endmodule

// File: rtl/softint_datapath.sv
module softint_datapath
  import softint_pkg::*;
#(
  parameter int SOFT_W    = 17,
  parameter int PIL_W     = 4,
  parameter int DATA_W    = 64,
  parameter int TIMER_BIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  softStrobe_t       strb,
  input  logic [SOFT_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [SOFT_W-1:0] softQ,
  output logic [PIL_W-1:0]  pilQ,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [SOFT_W-1:0] TIMER_MASK = SOFT_W'(1) << TIMER_BIT;

  logic [SOFT_W-1:0] swNext;
  logic [SOFT_W-1:0] softNext;

  // Software merge first, timer match applied on top
  always_comb begin
    swNext = softQ;
    if (strb.wrDirect)   swNext = wrData;
    else if (strb.wrSet) swNext = softQ | wrData;
    else if (strb.wrClr) swNext = softQ & ~wrData;
    softNext = strb.timerSet ? (swNext | TIMER_MASK) : swNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softQ <= '0;
      pilQ  <= '0;
    end else begin
      softQ <= softNext;
      if (strb.wrPil) pilQ <= wrData[PIL_W-1:0];
    end
  end

  always_comb begin
    if (rdAddr == ADDR_PIL) rdData = DATA_W'(pilQ);
    else                    rdData = DATA_W'(softQ);
  end

  AST_SET_MERGES: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrSet && !strb.timerSet) |=> softQ == ($past(softQ) | $past(wrData))); // R4
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrClr && !strb.timerSet) |=> (softQ & $past(wrData)) == '0); // R5
  AST_CLR_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrClr && !strb.timerSet) |=> (softQ & ~$past(wrData)) == ($past(softQ) & ~$past(wrData))); // R5
  AST_DIRECT_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrDirect && !strb.timerSet) |=> softQ == $past(wrData)); // R6
  AST_PIL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrPil |=> $stable(pilQ)); // R6
  AST_TIMER_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strb.timerSet |=> softQ[TIMER_BIT]); // R7

endmodule

// File: rtl/softint_mask.sv
module softint_mask #(
  parameter int SOFT_W       = 17,
  parameter int PIL_W        = 4,
  parameter int TICK_BIT     = 0,
  parameter int TIMER_BIT    = 16,
  parameter int SHARED_LEVEL = 14
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [SOFT_W-1:0]     softIn,
  input  logic [PIL_W-1:0]      pilIn,
  output logic [(1<<PIL_W)-1:0] levelReq
);

  localparam int NUM_LEVELS = 1 << PIL_W;
  localparam logic [PIL_W-1:0] SHARED_LVL = PIL_W'(SHARED_LEVEL);
  localparam logic [NUM_LEVELS-1:0] SHARED_ONEHOT = NUM_LEVELS'(1) << SHARED_LEVEL;

  logic [NUM_LEVELS-1:0] reqNext;
  logic                  sharedHit;

  assign sharedHit  = (softIn[TICK_BIT] | softIn[TIMER_BIT]) & (pilIn < SHARED_LVL);
  assign reqNext[0] = 1'b0;

  for (genvar lvl = 1; lvl < NUM_LEVELS; lvl++) begin : g_level
    localparam logic [PIL_W-1:0] LVL = PIL_W'(lvl);
    logic ownHit;
    assign ownHit = softIn[lvl] & (LVL > pilIn);
    if (lvl == SHARED_LEVEL) begin : g_shared
      assign reqNext[lvl] = ownHit | sharedHit;
    end else begin : g_plain
      assign reqNext[lvl] = ownHit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) levelReq <= '0;
    else       levelReq <= reqNext;
  end

  AST_PIL_BLOCKS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (levelReq & ((NUM_LEVELS'(2) << $past(pilIn)) - NUM_LEVELS'(1))) == '0); // R3
  AST_TIMER_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    (softIn[TIMER_BIT] && pilIn < SHARED_LVL) |=> levelReq[SHARED_LEVEL]); // R1
  AST_TICK_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    (softIn[TICK_BIT] && pilIn < SHARED_LVL) |=> levelReq[SHARED_LEVEL]); // R2
  AST_NO_STRAY_REQ: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (levelReq & ~SHARED_ONEHOT & ~$past(softIn[NUM_LEVELS-1:0])) == '0); // R3
  AST_LEVEL0_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !levelReq[0]); // R3

endmodule

// File: rtl/softint_mask_unit.sv
module softint_mask_unit
  import softint_pkg::*;
#(
  parameter int SOFT_W       = 17,
  parameter int PIL_W        = 4,
  parameter int DATA_W       = 64,
  parameter int TICK_BIT     = 0,
  parameter int TIMER_BIT    = 16,
  parameter int SHARED_LEVEL = 14
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [1:0]            wrAddr,
  input  logic [SOFT_W-1:0]     wrData,
  input  logic                  timerHit,
  input  logic [1:0]            rdAddr,
  output logic [DATA_W-1:0]     rdData,
  output logic [(1<<PIL_W)-1:0] levelReq
);

  softStrobe_t       strb;
  logic [SOFT_W-1:0] softQ;
  logic [PIL_W-1:0]  pilQ;

  softint_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .timerHit(timerHit), .strb(strb)
  );

  softint_datapath #(
    .SOFT_W(SOFT_W), .PIL_W(PIL_W), .DATA_W(DATA_W), .TIMER_BIT(TIMER_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdAddr(rdAddr),
    .softQ(softQ), .pilQ(pilQ), .rdData(rdData)
  );

  softint_mask #(
    .SOFT_W(SOFT_W), .PIL_W(PIL_W), .TICK_BIT(TICK_BIT),
    .TIMER_BIT(TIMER_BIT), .SHARED_LEVEL(SHARED_LEVEL)
  ) u_mask (
    .clk(clk), .rstN(rstN), .softIn(softQ), .pilIn(pilQ), .levelReq(levelReq)
  );

endmodule

// File: tb/softint_mask_unit_bench.sv
module softint_mask_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [16:0] wrData = '0;
  logic        timerHit = 1'b0;
  logic [1:0]  rdAddr = '0;
  logic [63:0] rdData;
  logic [15:0] levelReq;

  int total = 0;
  int bad = 0;

  softint_mask_unit u_softint_mask_unit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .timerHit(timerHit), .rdAddr(rdAddr), .rdData(rdData), .levelReq(levelReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] expReq(logic [16:0] s, int p);
    logic [15:0] r = '0;
    for (int lvl = 1; lvl < 16; lvl++)
      r[lvl] = (s[lvl] && lvl > p) || (lvl == 14 && p < 14 && (s[0] || s[16]));
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [16:0] d, logic tmr);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d; timerHit = tmr;
    @(negedge clk);
    wrEn = 1'b0; timerHit = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [63:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R8 watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] v;
    logic [31:0] lf;
    logic [16:0] s;
    int p;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 req", 64'(levelReq), 64'h0);
    rd(2'd0, v); chk("R9 word", v, 64'h0);
    rd(2'd3, v); chk("R9 pil", v, 64'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R8 latency: state on first edge, request on the next
    wr(2'd0, 17'h00020, 1'b0);
    chk("R8 req still old", 64'(levelReq), 64'h0);
    rd(2'd0, v); chk("R8 word updated", v, 64'h20);
    @(negedge clk);
    chk("R8 req updated", 64'(levelReq), 64'h20);

    // R1 R2 R3 sweep: every PIL against every single bit
    for (int pl = 0; pl < 16; pl++) begin
      wr(2'd3, 17'(pl), 1'b0);
      for (int b = 0; b < 17; b++) begin
        wr(2'd0, 17'(1) << b, 1'b0);
        @(negedge clk);
        if (b == 16)     chk("R1 timer bit", 64'(levelReq), 64'(expReq(17'h10000, pl)));
        else if (b == 0) chk("R2 tick bit", 64'(levelReq), 64'(expReq(17'h1, pl)));
        else             chk("R3 plain bit", 64'(levelReq), 64'(expReq(17'(1) << b, pl)));
      end
      rd(2'd3, v); chk("R10 pil read", v, 64'(pl));
    end

    // R4 set alias, R5 clear alias, R10 read of word
    wr(2'd3, 17'h1_FFF7, 1'b0);
    rd(2'd3, v); chk("R6 pil low bits", v, 64'h7);
    wr(2'd0, 17'h00F0F, 1'b0);
    wr(2'd1, 17'h10003, 1'b0);
    rd(2'd1, v); chk("R4 set or", v, 64'h10F0F);
    wr(2'd2, 17'h00F03, 1'b0);
    rd(2'd2, v); chk("R5 clear", v, 64'h1000C);
    @(negedge clk);
    chk("R5 req after clear", 64'(levelReq), 64'(expReq(17'h1000C, 7)));

    // R6 PIL write alone re-evaluates requests
    wr(2'd3, 17'd12, 1'b0);
    wr(2'd0, 17'h00200, 1'b0);
    @(negedge clk);
    chk("R6 masked", 64'(levelReq), 64'h0);
    wr(2'd3, 17'd8, 1'b0);
    @(negedge clk);
    chk("R6 pil unmasks", 64'(levelReq), 64'h200);

    // R7 timer match alone and against a clear
    wr(2'd0, 17'h0, 1'b0);
    wr(2'd3, 17'd3, 1'b0);
    @(negedge clk); timerHit = 1'b1;
    @(negedge clk); timerHit = 1'b0;
    rd(2'd0, v); chk("R7 timer sets", v, 64'h10000);
    @(negedge clk);
    chk("R7 timer req", 64'(levelReq), 64'h4000);
    wr(2'd0, 17'h0F0F0, 1'b0);
    wr(2'd2, 17'h1FFFF, 1'b1);
    rd(2'd0, v); chk("R7 timer beats clear", v, 64'h10000);
    wr(2'd3, 17'd14, 1'b0);
    @(negedge clk);
    chk("R1 withdrawn at 14", 64'(levelReq), 64'h0);

    // Pseudo-random words and levels
    lf = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      lf = lf * 32'd1103515245 + 32'd12345;
      s = lf[30:14];
      p = int'(lf[7:4]);
      wr(2'd0, s, 1'b0);
      wr(2'd3, 17'(p), 1'b0);
      @(negedge clk);
      chk("R3 random", 64'(levelReq), 64'(expReq(s, p)));
      rd(2'd0, v); chk("R10 random read", v, 64'(s));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule